// File: doc/BRIEF.md
# Multi-Width Add/Subtract Status Flag Generator

This block is purely combinational. It adds or subtracts two operands at 8, 16 or 32 bits and produces six status flags: carry, parity, auxiliary carry, zero, sign and overflow. A width select picks how many low bits of the operands take part. The result is truncated to that width, and the bits above it read as zero.

Carry, overflow and sign are taken at the top bit of the selected width. Parity always looks at the low result byte, and auxiliary carry always looks at the nibble boundary at bit 3. A carry-in allows multi-word adds. On subtraction that same input acts as a borrow-in.

Subtraction is formed as A plus the inverted B plus one, less the borrow-in. In subtract mode the carry and auxiliary flags are inverted, so that they report a borrow rather than a carry. The block would normally sit beside an ALU adder. Whatever writes the flags into a register is separate from this block.

Top module: `flag_gen`

## Requirements
- R1: With `sub_sel`=0, `result` equals (A + B + `carry_in`) modulo 2^N. N is 8, 16 or 32, chosen by `width_sel`: 2'b00 selects 8, 2'b01 selects 16 and 2'b10 selects 32. Only the low N bits of each operand are used.
- R2: With `sub_sel`=1, `result` equals (A - B - `carry_in`) modulo 2^N, where `carry_in` acts as a borrow-in.
- R3: `flag_cf` is the carry out of bit N-1 on addition. On subtraction it is 1 when a borrow is needed into bit N-1, meaning unsigned A < B + borrow-in.
- R4: `flag_of` is 1 when the signed two's-complement result at width N does not fit in N bits.
- R5: `flag_af` is the carry out of bit 3 on addition. On subtraction it is 1 when the low nibble of A is smaller than the low nibble of B plus the borrow-in. This holds at every width.
- R6: `flag_pf` is 1 when `result[7:0]` contains an even number of ones, at every width.
- R7: `flag_zf` is 1 exactly when the N-bit result is zero.
- R8: `flag_sf` equals bit N-1 of the result.
- R9: `width_sel` = 2'b11 behaves exactly as the 32-bit width.
- R10: The bits of `result` at positions N and above are zero, whatever the upper operand bits hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand (minuend on subtract) |
| op_b | input | 32 | Second operand (subtrahend on subtract) |
| carry_in | input | 1 | Carry-in on add, borrow-in on subtract |
| sub_sel | input | 1 | 0 = add, 1 = subtract |
| width_sel | input | 2 | 00 = 8-bit, 01 = 16-bit, 10/11 = 32-bit |
| result | output | 32 | Result truncated to the selected width, upper bits zero |
| flag_cf | output | 1 | Carry / borrow at the top bit of the width |
| flag_pf | output | 1 | Even parity of the low result byte |
| flag_af | output | 1 | Carry / borrow at the bit-3 boundary |
| flag_zf | output | 1 | Result within width is zero |
| flag_sf | output | 1 | Top bit of the result within width |
| flag_of | output | 1 | Signed overflow at the selected width |

## Verification
Several relations between the ports are checked whenever the inputs change:
- parity against the low result byte;
- zero against the whole result;
- sign against the top bit chosen by the width select;
- the zeroing of result bits above the width;
- overflow against the operand and result signs.

The bench's scenarios are the only evidence for the following:
- the arithmetic value of the result;
- the direction of carry and auxiliary carry on add versus subtract;
- the effect of the borrow-in;
- the reserved width code behaving as 32-bit.

The scenarios sit at each width's wrap points, at nibble crossings and on a pseudo-random sweep.

// File: rtl/flag_gen.sv
module flag_gen #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          carry_in,
  input  logic          sub_sel,
  input  logic [1:0]    width_sel,
  output logic [DW-1:0] result,
  output logic          flag_cf,
  output logic          flag_pf,
  output logic          flag_af,
  output logic          flag_zf,
  output logic          flag_sf,
  output logic          flag_of
);

  logic [DW-1:0] b_eff;
  logic          c_low;
  logic [DW:0]   sum;
  logic [DW-1:0] keep;
  logic          c_top_out;
  logic          c_top_in;
  logic          top_bit;
  logic          nib_carry;

  assign b_eff = sub_sel ? ~op_b : op_b;
  assign c_low = carry_in ^ sub_sel;
  assign sum   = {1'b0, op_a} + {1'b0, b_eff} + {{DW{1'b0}}, c_low};

  assign nib_carry = op_a[4] ^ b_eff[4] ^ sum[4];

  always_comb begin
    keep = '0;
    case (width_sel)
      2'b00: begin
        keep[7:0] = '1;
        c_top_out = op_a[8] ^ b_eff[8] ^ sum[8];
        c_top_in  = op_a[7] ^ b_eff[7] ^ sum[7];
        top_bit   = sum[7];
      end
      2'b01: begin
        keep[15:0] = '1;
        c_top_out  = op_a[16] ^ b_eff[16] ^ sum[16];
        c_top_in   = op_a[15] ^ b_eff[15] ^ sum[15];
        top_bit    = sum[15];
      end
      default: begin
        keep      = '1;
        c_top_out = sum[DW];
        c_top_in  = op_a[DW-1] ^ b_eff[DW-1] ^ sum[DW-1];
        top_bit   = sum[DW-1];
      end
    endcase
  end

  assign result  = sum[DW-1:0] & keep;
  assign flag_cf = c_top_out ^ sub_sel;
  assign flag_af = nib_carry ^ sub_sel;
  assign flag_of = c_top_out ^ c_top_in;
  assign flag_sf = top_bit;
  assign flag_zf = ~|result;
  assign flag_pf = ~^result[7:0];

endmodule

// File: rtl/flag_gen_chk.sv
module flag_gen_chk #(
  parameter int unsigned DW = 32
) (
  input logic [DW-1:0] op_a,
  input logic [DW-1:0] op_b,
  input logic          sub_sel,
  input logic [1:0]    width_sel,
  input logic [DW-1:0] result,
  input logic          flag_pf,
  input logic          flag_zf,
  input logic          flag_sf,
  input logic          flag_of
);

  logic sa, sb, sr;

  always_comb begin
    case (width_sel)
      2'b00:   begin sa = op_a[7];    sb = op_b[7];    sr = result[7];    end
      2'b01:   begin sa = op_a[15];   sb = op_b[15];   sr = result[15];   end
      default: begin sa = op_a[DW-1]; sb = op_b[DW-1]; sr = result[DW-1]; end
    endcase
  end

  always_comb begin
    a_r6_parity: assert ((^{flag_pf, result[7:0]}) == 1'b1)
      else $error("parity flag disagrees with low result byte");
    a_r7_zero: assert (flag_zf == (result == '0))
      else $error("zero flag disagrees with result");
    a_r8_sign: assert (flag_sf == sr)
      else $error("sign flag disagrees with top result bit");
    a_r10_upper: assert (width_sel == 2'b00 ? result[DW-1:8] == '0 :
                         width_sel == 2'b01 ? result[DW-1:16] == '0 : 1'b1)
      else $error("result bits above width not zero");
    a_r4_overflow: assert (flag_of == ((sa == (sb ^ sub_sel)) && (sr != sa)))
      else $error("overflow flag disagrees with operand/result signs");
  end

endmodule

bind flag_gen flag_gen_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_flag_gen.sv
module sim_flag_gen;
  localparam time PERIOD = 10ns;

  typedef struct {
    logic [31:0] res;
    logic cf, pf, af, zf, sf, of;
    string tag;
  } exp_t;

  logic clk = 0;
  logic rst = 1;
  logic [31:0] op_a = '0, op_b = '0;
  logic carry_in = 0, sub_sel = 0;
  logic [1:0] width_sel = 2'b00;
  logic [31:0] result;
  logic flag_cf, flag_pf, flag_af, flag_zf, flag_sf, flag_of;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t sb_q[$];

  always #(PERIOD/2) clk = ~clk;

  flag_gen u0 (.*);

  function automatic exp_t model(logic [31:0] a, logic [31:0] b, logic c,
                                 logic s, logic [1:0] w, string tag);
    exp_t e;
    int n;
    longint unsigned mask, aw, bw, full, r;
    longint sa, sbv, sr, half;
    n    = (w == 2'b00) ? 8 : (w == 2'b01) ? 16 : 32;
    mask = (64'd1 << n) - 1;
    half = longint'(64'd1 << (n - 1));
    aw   = a & mask;
    bw   = b & mask;
    sa   = (aw >= half) ? longint'(aw) - 2 * half : longint'(aw);
    sbv  = (bw >= half) ? longint'(bw) - 2 * half : longint'(bw);
    if (!s) begin
      full = aw + bw + c;
      r    = full & mask;
      e.cf = full[n];
      e.af = ((a & 32'hF) + (b & 32'hF) + c) > 15;
      sr   = sa + sbv + c;
    end else begin
      r    = (aw - bw - c) & mask;
      e.cf = aw < bw + c;
      e.af = (a & 32'hF) < ((b & 32'hF) + c);
      sr   = sa - sbv - c;
    end
    e.res = r[31:0];
    e.of  = (sr > half - 1) || (sr < -half);
    e.zf  = (r == 0);
    e.sf  = r[n-1];
    e.pf  = ~^r[7:0];
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(logic [31:0] a, logic [31:0] b, logic c, logic s,
                       logic [1:0] w, string tag);
    @(posedge clk);
    op_a = a; op_b = b; carry_in = c; sub_sel = s; width_sel = w;
    sb_q.push_back(model(a, b, c, s, w, tag));
  endtask

  task automatic fixed(logic [31:0] a, logic [31:0] b, logic c, logic s,
                       logic [1:0] w, string tag, exp_t want);
    exp_t m;
    m = model(a, b, c, s, w, tag);
    if (m.res !== want.res || m.cf !== want.cf || m.af !== want.af ||
        m.of !== want.of || m.zf !== want.zf || m.sf !== want.sf || m.pf !== want.pf)
      $display("note: model/hand mismatch for %s", tag);
    @(posedge clk);
    op_a = a; op_b = b; carry_in = c; sub_sel = s; width_sel = w;
    want.tag = tag;
    sb_q.push_back(want);
  endtask

  function automatic exp_t mk(logic [31:0] r, logic cf, logic pf, logic af,
                              logic zf, logic sf, logic of);
    exp_t e;
    e.res = r; e.cf = cf; e.pf = pf; e.af = af; e.zf = zf; e.sf = sf; e.of = of;
    e.tag = "";
    return e;
  endfunction

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (result !== e.res || flag_cf !== e.cf || flag_pf !== e.pf ||
          flag_af !== e.af || flag_zf !== e.zf || flag_sf !== e.sf ||
          flag_of !== e.of) begin
        errors++;
        $display("FAIL %s: got res=%h cf%b pf%b af%b zf%b sf%b of%b exp res=%h cf%b pf%b af%b zf%b sf%b of%b",
                 e.tag, result, flag_cf, flag_pf, flag_af, flag_zf, flag_sf, flag_of,
                 e.res, e.cf, e.pf, e.af, e.zf, e.sf, e.of);
      end
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(posedge clk);
    rst = 0;
    // R7 R6 reset-like all-zero inputs
    fixed(32'h0, 32'h0, 0, 0, 2'b00, "R7 R6 zero inputs",          mk(32'h0, 0,1,0,1,0,0));
    fixed(32'hFF, 32'h01, 0, 0, 2'b00, "R3 R5 R1 8-bit wrap",      mk(32'h0, 1,1,1,1,0,0));
    fixed(32'h7F, 32'h01, 0, 0, 2'b00, "R4 R8 8-bit overflow",     mk(32'h80,0,0,1,0,1,1));
    fixed(32'hFFFF, 32'h1, 0, 0, 2'b01, "R3 16-bit carry",         mk(32'h0, 1,1,1,1,0,0));
    fixed(32'hFFFFFFFF, 32'h1, 0, 0, 2'b10, "R3 32-bit carry",     mk(32'h0, 1,1,1,1,0,0));
    fixed(32'h7FFFFFFF, 32'h1, 0, 0, 2'b11, "R9 code 11 is 32-bit",mk(32'h80000000,0,1,1,0,1,1));
    fixed(32'h12345600, 32'hABCDEF01, 0, 0, 2'b00, "R10 upper bits cleared", mk(32'h01,0,0,0,0,0,0));
    fixed(32'h00, 32'h01, 0, 1, 2'b00, "R2 R3 8-bit borrow",       mk(32'hFF,1,1,1,0,1,0));
    fixed(32'h10, 32'h0F, 1, 1, 2'b00, "R2 R5 borrow-in",          mk(32'h0, 0,1,1,1,0,0));
    fixed(32'h8000, 32'h1, 0, 1, 2'b01, "R4 16-bit sub overflow",  mk(32'h7FFF,0,1,1,0,0,1));
    fixed(32'hFFFF0002, 32'h1, 0, 0, 2'b10, "R6 parity low byte only", mk(32'hFFFF0003,0,1,0,0,1,0));
    fixed(32'h0000000F, 32'h1, 0, 0, 2'b10, "R5 32-bit nibble carry", mk(32'h10,0,0,1,0,0,0));
    fixed(32'hFE, 32'h01, 1, 0, 2'b00, "R1 R3 carry-in",           mk(32'h0, 1,1,1,1,0,0));
    fixed(32'h5, 32'h5, 0, 1, 2'b10, "R7 R2 equal sub",            mk(32'h0, 0,1,0,1,0,0));
    lfsr = 32'hACE1_2357;
    for (int i = 0; i < 64; i++) begin
      logic [31:0] a, b;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      b = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      drive(a, b, a[3], b[5], 2'(i % 4), "R1 R2 R3 R4 R5 sweep");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule